// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel coordinate into a byte offset within a surface stored as 8x8 micro-tiles. The tiles run in row-major order across the surface. Each request carries the x and y coordinates, the element size in bytes, the surface pitch in elements, and two flags that pick a color, depth or stencil layout. The block returns the byte offset through a two-stage registered pipeline that has valid/ready handshakes on both sides.

Inside each tile, the low three bits of x and y are interleaved into a 6-bit pixel index. The bit order of that index depends on the element size and on whether the surface holds color or depth. A 4-byte depth surface keeps its 8-bit stencil values and its 24-bit depth values in two separate regions of every tile. The stencil flag selects which of the two regions is addressed.

The block covers single-sample, single-slice surfaces only. The pitch must be a multiple of 8 elements.

Top module: `tile_addr_gen`

## Requirements
- R1: The offset is (floor(y/8) * (pitch/8) + floor(x/8)) * 64 * element_bytes, plus the in-tile element offset.
- R2: For a depth surface, the pixel index, written from bit 5 down to bit 0, is {y[2], x[2], y[1], x[1], y[0], x[0]}.
- R3: For 1-byte color, the pixel index is {y[2], y[0], y[1], x[2], x[1], x[0]}, so y[0] sits above y[1].
- R4: For 2-byte color, the pixel index is {y[2], y[1], y[0], x[2], x[1], x[0]}.
- R5: For 4-byte color, the pixel index is {y[2], y[1], x[2], y[0], x[1], x[0]}.
- R6: For color surfaces, and for depth surfaces with 1-byte or 2-byte elements, the in-tile element offset is pixel_index * element_bytes.
- R7: For 4-byte depth, stencil_i=1 addresses the stencil byte at pixel_index inside the tile. With stencil_i=0 the depth value is addressed at 64 + 3 * pixel_index.
- R8: stencil_i has no effect unless depth_i=1 and elem_bytes_i=4.
- R9: elem_bytes_i holds the element size in bytes; the legal values are 1, 2 and 4. Any other value gives err_o=1 and offset_o=0 on the matching result. Legal values give err_o=0.
- R10: If a request is accepted while the output register is empty, its result appears on out_valid_o after the second rising edge, counting the accepting edge as the first.
- R11: While out_valid_o=1 and out_ready_i=0, out_valid_o, offset_o and err_o hold steady. in_ready_o drops only when both stages are full and the output is stalled. Results leave in the order their requests arrived, and none is lost.
- R12: After reset, out_valid_o=0 and in_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request accepted when high together with in_valid_i |
| x_i | input | XW | Pixel x coordinate |
| y_i | input | YW | Pixel y coordinate |
| elem_bytes_i | input | 3 | Element size in bytes (1, 2, 4) |
| pitch_i | input | PW | Surface pitch in elements, multiple of 8 |
| depth_i | input | 1 | Surface is depth/stencil |
| stencil_i | input | 1 | Address the stencil region of a 4-byte depth tile |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts result |
| offset_o | output | OW | Byte offset |
| err_o | output | 1 | Illegal element size on this result |

## Verification
Single-bit coordinates such as y=1, y=2, y=4 and x=4 are run through every color size and through depth. Each lands on one bit of the pixel index, which separates the four interleave orders and exposes a swapped y[0]/y[1] pair. Mixed coordinates in a non-zero tile, together with an 8x8 corner at x=7, y=7, check the tile-index arithmetic against the element-offset scaling. The stencil and depth regions are compared at identical coordinates. Toggling the stencil flag on color and on 2-byte depth shows that it is ignored outside the 4-byte depth case. A stalled output with two requests queued checks that the handshake holds results and keeps their order.

// File: rtl/tag_pkg.sv
package tag_pkg;
  typedef enum logic [1:0] {
    SZ_1   = 2'd0,
    SZ_2   = 2'd1,
    SZ_4   = 2'd2,
    SZ_BAD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    RG_PLAIN = 2'd0,  // pix * bytes
    RG_STEN  = 2'd1,  // stencil plane of 32-bit depth tile
    RG_DEPTH = 2'd2   // 24-bit depth plane after stencil plane
  } region_e;

  localparam int unsigned TILE_DIM_LOG2 = 3;
  localparam int unsigned PIX_BITS      = 2 * TILE_DIM_LOG2;
  localparam int unsigned STEN_PLANE    = 1 << PIX_BITS;

  function automatic size_e decode_size(input logic [2:0] eb);
    case (eb)
      3'd1:    return SZ_1;
      3'd2:    return SZ_2;
      3'd4:    return SZ_4;
      default: return SZ_BAD;
    endcase
  endfunction
endpackage

// File: rtl/tag_pipe_reg.sv
module tag_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign ready_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/tag_pix_index.sv
module tag_pix_index
  import tag_pkg::*;
(
  input  logic [2:0] x_lo_i,
  input  logic [2:0] y_lo_i,
  input  size_e      size_i,
  input  logic       depth_i,
  output logic [5:0] pix_o
);
  logic [2:0] x, y;
  assign x = x_lo_i;
  assign y = y_lo_i;

  always_comb begin
    if (depth_i) begin
      pix_o = {y[2], x[2], y[1], x[1], y[0], x[0]};
    end else begin
      case (size_i)
        SZ_1:    pix_o = {y[2], y[0], y[1], x[2], x[1], x[0]};
        SZ_2:    pix_o = {y[2], y[1], y[0], x[2], x[1], x[0]};
        SZ_4:    pix_o = {y[2], y[1], x[2], y[0], x[1], x[0]};
        default: pix_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tag_tile_index.sv
module tag_tile_index #(
  parameter int unsigned XW = 14,
  parameter int unsigned YW = 14,
  parameter int unsigned PW = 15,
  parameter int unsigned IW = 24
) (
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  logic [PW-1:0] pitch_i,
  output logic [IW-1:0] tile_idx_o
);
  localparam int unsigned SH = tag_pkg::TILE_DIM_LOG2;

  logic [XW-SH-1:0] col;
  logic [YW-SH-1:0] row;
  logic [PW-SH-1:0] per_row;

  assign col     = x_i[XW-1:SH];
  assign row     = y_i[YW-1:SH];
  assign per_row = pitch_i[PW-1:SH];

  assign tile_idx_o = IW'(row) * IW'(per_row) + IW'(col);
endmodule

// File: rtl/tag_elem_offset.sv
module tag_elem_offset
  import tag_pkg::*;
#(
  parameter int unsigned IW = 24,
  parameter int unsigned OW = 32
) (
  input  logic [IW-1:0] tile_idx_i,
  input  logic [5:0]    pix_i,
  input  size_e         size_i,
  input  region_e       region_i,
  output logic [OW-1:0] offset_o
);
  logic [1:0]    sz_log2;
  logic [OW-1:0] tile_off;
  logic [OW-1:0] elem_off;

  assign sz_log2  = (size_i == SZ_BAD) ? 2'd0 : 2'(size_i);
  assign tile_off = OW'(tile_idx_i) << (PIX_BITS + 32'(sz_log2));

  always_comb begin
    case (region_i)
      RG_STEN:  elem_off = OW'(pix_i);
      RG_DEPTH: elem_off = OW'(STEN_PLANE) + OW'(pix_i) * OW'(3);
      default:  elem_off = OW'(pix_i) << sz_log2;
    endcase
  end

  assign offset_o = (size_i == SZ_BAD) ? '0 : tile_off + elem_off;
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tag_pkg::*;
#(
  parameter int unsigned XW = 14,
  parameter int unsigned YW = 14,
  parameter int unsigned PW = 15,
  parameter int unsigned OW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  logic [2:0]    elem_bytes_i,
  input  logic [PW-1:0] pitch_i,
  input  logic          depth_i,
  input  logic          stencil_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [OW-1:0] offset_o,
  output logic          err_o
);
  localparam int unsigned IW  = (YW - TILE_DIM_LOG2) + (PW - TILE_DIM_LOG2) + 1;
  localparam int unsigned S1W = IW + PIX_BITS + 2 + 2;
  localparam int unsigned S2W = OW + 1;

  typedef struct packed {
    logic [IW-1:0]       tile_idx;
    logic [PIX_BITS-1:0] pix;
    size_e               size;
    region_e             region;
  } s1_t;

  // stage 1: tile index multiply and pixel swizzle
  size_e         in_size;
  region_e       in_region;
  logic [5:0]    in_pix;
  logic [IW-1:0] in_tile_idx;
  s1_t           s1_d, s1_q;
  logic [S1W-1:0] s1_q_raw;
  logic          s1_valid, s1_ready;

  assign in_size = decode_size(elem_bytes_i);

  always_comb begin
    if (depth_i && in_size == SZ_4) in_region = stencil_i ? RG_STEN : RG_DEPTH;
    else                            in_region = RG_PLAIN;
  end

  tag_pix_index u_pix (
    .x_lo_i  (x_i[2:0]),
    .y_lo_i  (y_i[2:0]),
    .size_i  (in_size),
    .depth_i (depth_i),
    .pix_o   (in_pix)
  );

  tag_tile_index #(.XW(XW), .YW(YW), .PW(PW), .IW(IW)) u_tidx (
    .x_i        (x_i),
    .y_i        (y_i),
    .pitch_i    (pitch_i),
    .tile_idx_o (in_tile_idx)
  );

  assign s1_d = '{tile_idx: in_tile_idx, pix: in_pix, size: in_size, region: in_region};

  tag_pipe_reg #(.W(S1W)) u_s1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .ready_o (in_ready_o),
    .data_i  (s1_d),
    .valid_o (s1_valid),
    .ready_i (s1_ready),
    .data_o  (s1_q_raw)
  );
  assign s1_q = s1_t'(s1_q_raw);

  // stage 2: shift and add
  logic [OW-1:0]  s2_off;
  logic [S2W-1:0] s2_d, s2_q;

  tag_elem_offset #(.IW(IW), .OW(OW)) u_eoff (
    .tile_idx_i (s1_q.tile_idx),
    .pix_i      (s1_q.pix),
    .size_i     (s1_q.size),
    .region_i   (s1_q.region),
    .offset_o   (s2_off)
  );

  assign s2_d = {s1_q.size == SZ_BAD, s2_off};

  tag_pipe_reg #(.W(S2W)) u_s2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .ready_o (s1_ready),
    .data_i  (s2_d),
    .valid_o (out_valid_o),
    .ready_i (out_ready_i),
    .data_o  (s2_q)
  );

  assign err_o    = s2_q[OW];
  assign offset_o = s2_q[OW-1:0];
endmodule

// File: rtl/tag_checker.sv
module tag_checker #(
  parameter int unsigned OW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [OW-1:0] offset_o,
  input logic          err_o
);
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && err_o |-> offset_o == '0);  // R9

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(offset_o) && $stable(err_o));  // R11

  AST_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o && !out_ready_i);  // R11

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !out_valid_o |=> ##1 out_valid_o);  // R10

  AST_IDLE_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o && in_ready_o);  // R12
endmodule

bind tile_addr_gen tag_checker #(.OW(OW)) u_tag_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .offset_o    (offset_o),
  .err_o       (err_o)
);

// File: tb/tile_addr_gen_test.sv
module tile_addr_gen_test;
  localparam int XW = 14, YW = 14, PW = 15, OW = 32;

  typedef struct packed {
    logic [13:0] x;
    logic [13:0] y;
    logic [2:0]  eb;
    logic [14:0] pitch;
    logic        dep;
    logic        sten;
    logic [31:0] exp_off;
    logic        exp_err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{14'd0,    14'd0,    3'd4, 15'd64,   1'b0, 1'b0, 32'd0,       1'b0, 8'd1},  // R1 origin
    '{14'd5,    14'd1,    3'd4, 15'd64,   1'b0, 1'b0, 32'd52,      1'b0, 8'd5},  // R5
    '{14'd5,    14'd1,    3'd1, 15'd64,   1'b0, 1'b0, 32'd21,      1'b0, 8'd3},  // R3
    '{14'd5,    14'd1,    3'd2, 15'd64,   1'b0, 1'b0, 32'd26,      1'b0, 8'd4},  // R4
    '{14'd5,    14'd1,    3'd2, 15'd64,   1'b1, 1'b0, 32'd38,      1'b0, 8'd2},  // R2
    '{14'd5,    14'd1,    3'd4, 15'd64,   1'b1, 1'b0, 32'd121,     1'b0, 8'd7},  // R7 depth
    '{14'd5,    14'd1,    3'd4, 15'd64,   1'b1, 1'b1, 32'd19,      1'b0, 8'd7},  // R7 stencil
    '{14'd0,    14'd1,    3'd1, 15'd64,   1'b0, 1'b0, 32'd16,      1'b0, 8'd3},  // R3 y0 above y1
    '{14'd0,    14'd2,    3'd1, 15'd64,   1'b0, 1'b0, 32'd8,       1'b0, 8'd3},  // R3
    '{14'd0,    14'd2,    3'd2, 15'd64,   1'b0, 1'b0, 32'd32,      1'b0, 8'd4},  // R4
    '{14'd4,    14'd0,    3'd4, 15'd64,   1'b0, 1'b0, 32'd32,      1'b0, 8'd5},  // R5 x2
    '{14'd0,    14'd4,    3'd2, 15'd64,   1'b1, 1'b0, 32'd64,      1'b0, 8'd2},  // R2 y2
    '{14'd0,    14'd1,    3'd1, 15'd64,   1'b1, 1'b0, 32'd2,       1'b0, 8'd6},  // R6 1-byte depth
    '{14'd13,   14'd17,   3'd4, 15'd64,   1'b0, 1'b0, 32'd4404,    1'b0, 8'd1},  // R1
    '{14'd13,   14'd17,   3'd1, 15'd64,   1'b0, 1'b0, 32'd1109,    1'b0, 8'd1},  // R1
    '{14'd13,   14'd17,   3'd2, 15'd64,   1'b0, 1'b0, 32'd2202,    1'b0, 8'd6},  // R6
    '{14'd13,   14'd17,   3'd4, 15'd64,   1'b1, 1'b1, 32'd4371,    1'b0, 8'd7},  // R7
    '{14'd13,   14'd17,   3'd4, 15'd64,   1'b1, 1'b0, 32'd4473,    1'b0, 8'd7},  // R7
    '{14'd7,    14'd7,    3'd4, 15'd64,   1'b0, 1'b0, 32'd252,     1'b0, 8'd6},  // R6 corner
    '{14'd7,    14'd7,    3'd4, 15'd64,   1'b1, 1'b0, 32'd253,     1'b0, 8'd7},  // R7 corner
    '{14'd5,    14'd1,    3'd4, 15'd64,   1'b0, 1'b1, 32'd52,      1'b0, 8'd8},  // R8 color
    '{14'd5,    14'd1,    3'd2, 15'd64,   1'b1, 1'b1, 32'd38,      1'b0, 8'd8},  // R8 2-byte depth
    '{14'd13,   14'd17,   3'd3, 15'd64,   1'b0, 1'b0, 32'd0,       1'b1, 8'd9},  // R9
    '{14'd13,   14'd17,   3'd0, 15'd64,   1'b1, 1'b0, 32'd0,       1'b1, 8'd9},  // R9
    '{14'd1023, 14'd1023, 3'd4, 15'd1024, 1'b0, 1'b0, 32'd4194300, 1'b0, 8'd1}   // R1 far tile
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [XW-1:0] x = '0;
  logic [YW-1:0] y = '0;
  logic [2:0]    eb = 3'd4;
  logic [PW-1:0] pitch = 15'd64;
  logic          dep = 1'b0, sten = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [OW-1:0] offset;
  logic          err;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tile_addr_gen #(.XW(XW), .YW(YW), .PW(PW), .OW(OW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .x_i(x), .y_i(y), .elem_bytes_i(eb), .pitch_i(pitch), .depth_i(dep),
    .stencil_i(sten), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .offset_o(offset), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input vec_t v);
    while (!in_ready) @(negedge clk);
    x = v.x; y = v.y; eb = v.eb; pitch = v.pitch; dep = v.dep; sten = v.sten;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    for (int i = 0; i < 20 && !out_valid; i++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", 32'(out_valid), 0);
    chk("R12 in_ready in reset", 32'(in_ready), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12 out_valid after reset", 32'(out_valid), 0);
    chk("R12 in_ready after reset", 32'(in_ready), 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      push(VECS[i]);
      wait_out();
      chk($sformatf("R%0d vec%0d valid", VECS[i].req, i), 32'(out_valid), 1);
      chk($sformatf("R%0d vec%0d offset", VECS[i].req, i), offset, VECS[i].exp_off);
      chk($sformatf("R%0d vec%0d err", VECS[i].req, i), 32'(err), 32'(VECS[i].exp_err));
      @(negedge clk);
    end

    // R10 latency
    @(negedge clk);
    x = 14'd5; y = 14'd1; eb = 3'd4; dep = 1'b0; sten = 1'b0; pitch = 15'd64;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 not valid after one edge", 32'(out_valid), 0);
    @(negedge clk);
    chk("R10 valid after two edges", 32'(out_valid), 1);
    chk("R10 offset", offset, 52);
    @(negedge clk);

    // R11 backpressure and order
    out_ready = 1'b0;
    push('{14'd5, 14'd1, 3'd1, 15'd64, 1'b0, 1'b0, 32'd21, 1'b0, 8'd11});
    push('{14'd5, 14'd1, 3'd2, 15'd64, 1'b0, 1'b0, 32'd26, 1'b0, 8'd11});
    @(negedge clk);
    chk("R11 in_ready low when full", 32'(in_ready), 0);
    chk("R11 first held", offset, 21);
    repeat (3) @(negedge clk);
    chk("R11 still valid", 32'(out_valid), 1);
    chk("R11 first stable", offset, 21);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R11 second follows", offset, 26);
    chk("R11 second valid", 32'(out_valid), 1);
    @(negedge clk);
    chk("R11 drained", 32'(out_valid), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule